// File: doc/BRIEF.md
# Serial Port FIFO, Status and Interrupt Unit

This block sits between a register bus and the serial shift engine of a serial peripheral controller. It holds one transmit and one receive queue of 16-bit words, reports their fill levels and a compact status word, and gathers error and level events into an interrupt with raw, masked and clearable views. Two request lines tell an external DMA engine when the transmit queue wants data or the receive queue has enough to drain.

Software fills the transmit queue by writing the transmit data register and drains the receive queue by reading the receive data register. The serial engine pops transmit words and pushes received words with single-cycle strobes. Thresholds and watermarks are written while the controller is disabled. They are then frozen while it runs. Clearing the enable bit empties both queues.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: After reset both levels read 0, status (addr 3) reads 0x0C, raw interrupt (addr 10) reads 0x01, mask, enable, thresholds and DMA control read 0, and irq, dma_tx_req, dma_rx_req are low.
- R2: A register write to addr 12 appends reg_wdata to the transmit queue; eng_tx_data shows the oldest entry (0 when empty) and eng_tx_pop removes it; addr 1 reads the entry count, 0 to DEPTH.
- R3: A write to addr 12 while the transmit queue holds DEPTH entries is dropped and sets sticky raw bit 1 (transmit overflow).
- R4: eng_rx_push appends eng_rx_data to the receive queue; a read with reg_rd at addr 13 returns the oldest entry and removes it; addr 2 reads the entry count.
- R5: A read of addr 13 with an empty receive queue returns 0 and sets sticky raw bit 2 (receive underflow); eng_rx_push into a full receive queue is dropped and sets sticky raw bit 3 (receive overflow).
- R6: Status bits: bit0 follows eng_busy, bit1 transmit full, bit2 transmit empty, bit3 receive empty, bit4 receive full.
- R7: Raw bit 0 is high while the transmit queue is empty; raw bit 4 is high while the receive count is strictly greater than the receive threshold (addr 4).
- R8: A cycle with eng_cs_inactive high sets sticky raw bit 6.
- R9: Writing the clear register (addr 11): bit0 clears every sticky flag, bit1 clears receive underflow, bit2 clears receive overflow, bit3 clears transmit overflow; other flags are kept.
- R10: Masked status (addr 9) equals raw AND mask (addr 8, 7 bits); irq is high exactly when masked status is nonzero.
- R11: DMA control (addr 7) bit0 enables receive requests, bit1 transmit requests; dma_tx_req is high when enabled and the transmit count is at most its watermark (addr 5); dma_rx_req is high when enabled and the receive count exceeds its watermark (addr 6).
- R12: While enable (addr 0 bit0) is 1, writes to addr 4, 5 and 6 are ignored; otherwise they load and read back.
- R13: Any write to addr 0 with bit0 clear empties both queues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops at addr 13) |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data, combinational from reg_addr |
| eng_busy | input | 1 | Serial engine busy flag |
| eng_tx_pop | input | 1 | Engine takes one transmit word |
| eng_tx_data | output | DW | Oldest transmit word |
| eng_rx_push | input | 1 | Engine delivers one receive word |
| eng_rx_data | input | DW | Received word |
| eng_cs_inactive | input | 1 | Chip-select release event |
| irq | output | 1 | Combined interrupt |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |

## Verification
The bench builds the unit with DEPTH 32 and DW 16, the smaller of the two supported depths, which puts every fill level from empty to full and one past full within a short run. At each receive level from 0 to 32 it programs every threshold value 0 to 31 into the threshold and both watermarks and compares the level interrupt and both DMA requests against arithmetic on the level. All 128 mask values are swept against a fixed raw pattern, and the lock, flush and per-bit clear rules are checked through register reads.

// File: rtl/spi_fifo_irq_unit.sv
module spi_fifo_irq_unit #(
  parameter int DEPTH = 32,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [3:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          eng_busy,
  input  logic          eng_tx_pop,
  output logic [DW-1:0] eng_tx_data,
  input  logic          eng_rx_push,
  input  logic [DW-1:0] eng_rx_data,
  input  logic          eng_cs_inactive,
  output logic          irq,
  output logic          dma_tx_req,
  output logic          dma_rx_req
);
  localparam int PW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);
  localparam logic [LW-1:0] FULL = LW'(DEPTH);

  localparam logic [3:0] A_CTRL = 4'd0, A_TXLVL = 4'd1, A_RXLVL = 4'd2, A_STAT = 4'd3,
                         A_RXTHR = 4'd4, A_TXWM = 4'd5, A_RXWM = 4'd6, A_DMA = 4'd7,
                         A_MASK = 4'd8, A_ISTAT = 4'd9, A_IRAW = 4'd10, A_ICLR = 4'd11,
                         A_TXD = 4'd12, A_RXD = 4'd13;

  logic [DW-1:0] txmem [DEPTH];
  logic [DW-1:0] rxmem [DEPTH];
  logic [PW-1:0] txwp, txrp, rxwp, rxrp;
  logic [LW-1:0] txlvl, rxlvl, rxthr, txwm, rxwm;
  logic          en;
  logic [1:0]    dmactl;
  logic [6:0]    mask;
  logic          flg_txo, flg_rxu, flg_rxo, flg_csi;

  wire wr_at_ctrl = reg_wr && reg_addr == A_CTRL;
  wire flush      = wr_at_ctrl && !reg_wdata[0];
  wire thr_open   = reg_wr && !en;

  wire tx_full    = txlvl == FULL;
  wire tx_empty   = txlvl == '0;
  wire rx_full    = rxlvl == FULL;
  wire rx_empty   = rxlvl == '0;

  wire tx_push_req = reg_wr && reg_addr == A_TXD;
  wire tx_push     = tx_push_req && !tx_full;
  wire tx_pop      = eng_tx_pop && !tx_empty;
  wire rx_pop_req  = reg_rd && reg_addr == A_RXD;
  wire rx_pop      = rx_pop_req && !rx_empty;
  wire rx_push     = eng_rx_push && !rx_full;

  wire clr     = reg_wr && reg_addr == A_ICLR;
  wire clr_all = clr && reg_wdata[0];
  wire clr_rxu = clr && (reg_wdata[0] || reg_wdata[1]);
  wire clr_rxo = clr && (reg_wdata[0] || reg_wdata[2]);
  wire clr_txo = clr && (reg_wdata[0] || reg_wdata[3]);

  wire [4:0] status  = {rx_full, rx_empty, tx_empty, tx_full, eng_busy};
  wire [6:0] irq_raw = {flg_csi, 1'b0, rxlvl > rxthr, flg_rxo, flg_rxu, flg_txo, tx_empty};
  wire [6:0] irq_msk = irq_raw & mask;
  wire [DW-1:0] rx_head = rx_empty ? '0 : rxmem[rxrp];

  assign eng_tx_data = tx_empty ? '0 : txmem[txrp];
  assign irq         = |irq_msk;
  assign dma_tx_req  = dmactl[1] && txlvl <= txwm;
  assign dma_rx_req  = dmactl[0] && rxlvl > rxwm;

  always_ff @(posedge clk) begin
    if (tx_push) txmem[txwp] <= reg_wdata;
    if (rx_push) rxmem[rxwp] <= eng_rx_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      txwp <= '0; txrp <= '0; txlvl <= '0;
      rxwp <= '0; rxrp <= '0; rxlvl <= '0;
    end else begin
      if (tx_push) txwp <= txwp + 1'b1;
      if (tx_pop)  txrp <= txrp + 1'b1;
      if (rx_push) rxwp <= rxwp + 1'b1;
      if (rx_pop)  rxrp <= rxrp + 1'b1;
      txlvl <= txlvl + LW'(tx_push) - LW'(tx_pop);
      rxlvl <= rxlvl + LW'(rx_push) - LW'(rx_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= 1'b0; dmactl <= '0; mask <= '0;
      rxthr <= '0; txwm <= '0; rxwm <= '0;
    end else begin
      if (wr_at_ctrl) en <= reg_wdata[0];
      if (reg_wr && reg_addr == A_DMA)  dmactl <= reg_wdata[1:0];
      if (reg_wr && reg_addr == A_MASK) mask <= reg_wdata[6:0];
      if (thr_open && reg_addr == A_RXTHR) rxthr <= reg_wdata[LW-1:0];
      if (thr_open && reg_addr == A_TXWM)  txwm  <= reg_wdata[LW-1:0];
      if (thr_open && reg_addr == A_RXWM)  rxwm  <= reg_wdata[LW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flg_txo <= 1'b0; flg_rxu <= 1'b0; flg_rxo <= 1'b0; flg_csi <= 1'b0;
    end else begin
      flg_txo <= (flg_txo && !clr_txo) || (tx_push_req && tx_full);
      flg_rxu <= (flg_rxu && !clr_rxu) || (rx_pop_req && rx_empty);
      flg_rxo <= (flg_rxo && !clr_rxo) || (eng_rx_push && rx_full);
      flg_csi <= (flg_csi && !clr_all) || eng_cs_inactive;
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = DW'(en);
      A_TXLVL: reg_rdata = DW'(txlvl);
      A_RXLVL: reg_rdata = DW'(rxlvl);
      A_STAT:  reg_rdata = DW'(status);
      A_RXTHR: reg_rdata = DW'(rxthr);
      A_TXWM:  reg_rdata = DW'(txwm);
      A_RXWM:  reg_rdata = DW'(rxwm);
      A_DMA:   reg_rdata = DW'(dmactl);
      A_MASK:  reg_rdata = DW'(mask);
      A_ISTAT: reg_rdata = DW'(irq_msk);
      A_IRAW:  reg_rdata = DW'(irq_raw);
      A_RXD:   reg_rdata = rx_head;
      default: reg_rdata = '0;
    endcase
  end

  p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    txlvl <= FULL && rxlvl <= FULL);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push_req && tx_full && !eng_tx_pop) |=> (txlvl == FULL && flg_txo));

  p_underflow_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop_req && rx_empty) |=> flg_rxu);

  p_irq_needs_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask != '0));

  p_thr_locked_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (en && reg_wr && reg_addr == A_RXTHR) |=> $stable(rxthr));

  p_flush_empties_r13: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (txlvl == '0 && rxlvl == '0));
endmodule

// File: tb/spi_fifo_irq_unit_test.sv
`timescale 1ns/1ps
module spi_fifo_irq_unit_test;
  localparam int D = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0, eng_rx_data = '0;
  logic [15:0] reg_rdata, eng_tx_data;
  logic eng_busy = 1'b0, eng_tx_pop = 1'b0, eng_rx_push = 1'b0, eng_cs_inactive = 1'b0;
  logic irq, dma_tx_req, dma_rx_req;
  int vectors = 0, errors = 0;
  logic [15:0] d;

  always #10 clk = ~clk;

  spi_fifo_irq_unit #(.DEPTH(D), .DW(16)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_busy(eng_busy),
    .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data), .eng_rx_push(eng_rx_push),
    .eng_rx_data(eng_rx_data), .eng_cs_inactive(eng_cs_inactive), .irq(irq),
    .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] v);
    @(negedge clk); reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #2 v = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [15:0] v);
    @(negedge clk); reg_addr = a; #2 v = reg_rdata;
  endtask

  task automatic epush(input logic [15:0] v);
    @(negedge clk); eng_rx_push = 1'b1; eng_rx_data = v;
    @(negedge clk); eng_rx_push = 1'b0;
  endtask

  task automatic epop(output logic [15:0] v);
    @(negedge clk); v = eng_tx_data; eng_tx_pop = 1'b1;
    @(negedge clk); eng_tx_pop = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    peek(4'd1, d); chk("R1 txlvl", d, 0);
    peek(4'd2, d); chk("R1 rxlvl", d, 0);
    peek(4'd3, d); chk("R1 status", d, 16'h0C);
    peek(4'd10, d); chk("R1 raw", d, 16'h01);
    peek(4'd8, d); chk("R1 mask", d, 0);
    peek(4'd0, d); chk("R1 enable", d, 0);
    peek(4'd4, d); chk("R1 rxthr", d, 0);
    peek(4'd7, d); chk("R1 dmactl", d, 0);
    chk("R1 outputs", {irq, dma_tx_req, dma_rx_req}, 0);

    // R2 R6 transmit fill sweep
    for (int i = 0; i < D; i++) begin
      wr(4'd12, 16'hA000 + 16'(3 * i));
      peek(4'd1, d); chk("R2 txlvl", d, i + 1);
      peek(4'd3, d); chk("R6 status tx", d, ((i + 1 == D) ? 16'h02 : 16'h00) | 16'h08);
    end
    // R3 overflow
    wr(4'd12, 16'hDEAD);
    peek(4'd1, d); chk("R3 txlvl kept", d, D);
    peek(4'd10, d); chk("R3 raw txo", d, 16'h02);
    for (int i = 0; i < D; i++) begin
      epop(d); chk("R2 tx order", d, 16'hA000 + 16'(3 * i));
      peek(4'd1, d); chk("R2 txlvl drain", d, D - 1 - i);
    end
    chk("R2 empty head", eng_tx_data, 0);
    peek(4'd10, d); chk("R7 raw tx empty", d, 16'h03);
    eng_busy = 1'b1;
    peek(4'd3, d); chk("R6 busy", d, 16'h0D);
    eng_busy = 1'b0;

    // R9 per-bit clear
    wr(4'd11, 16'h0004); peek(4'd10, d); chk("R9 other bit kept", d, 16'h03);
    wr(4'd11, 16'h0008); peek(4'd10, d); chk("R9 clear txo", d, 16'h01);

    // R4 R7 R11 level vs threshold sweep
    wr(4'd7, 16'h0003);
    for (int l = 0; l <= D; l++) begin
      if (l > 0) begin
        epush(16'hB000 + 16'(l - 1));
        wr(4'd12, 16'h5000 + 16'(l));
      end
      peek(4'd2, d); chk("R4 rxlvl", d, l);
      peek(4'd3, d);
      chk("R6 status sweep", d, ((l == D) ? 16'h12 : 16'h00) | ((l == 0) ? 16'h0C : 16'h00));
      for (int t = 0; t < D; t++) begin
        wr(4'd4, 16'(t)); wr(4'd5, 16'(t)); wr(4'd6, 16'(t));
        peek(4'd10, d);
        chk("R7 raw level", d, ((l > t) ? 16'h10 : 16'h00) | ((l == 0) ? 16'h01 : 16'h00));
        chk("R11 rx req", dma_rx_req, l > t);
        chk("R11 tx req", dma_tx_req, l <= t);
      end
    end
    wr(4'd7, 16'h0000);
    chk("R11 disabled", {dma_tx_req, dma_rx_req}, 0);
    // R5 receive overflow, drain, underflow
    epush(16'hFFFF);
    peek(4'd2, d); chk("R5 rxlvl kept", d, D);
    peek(4'd10, d); chk("R5 raw rxo", d, 16'h18);
    for (int j = 0; j < D; j++) begin
      rd(4'd13, d); chk("R4 rx order", d, 16'hB000 + 16'(j));
    end
    peek(4'd2, d); chk("R4 rxlvl drained", d, 0);
    rd(4'd13, d); chk("R5 empty read", d, 0);
    peek(4'd10, d); chk("R5 raw rxu", d, 16'h0C);

    // R10 mask sweep
    for (int m = 0; m < 128; m++) begin
      wr(4'd8, 16'(m));
      peek(4'd9, d); chk("R10 masked", d, 16'h0C & 16'(m));
      chk("R10 irq", irq, (m & 12) != 0);
    end

    // R8 chip-select event, R9 clears
    @(negedge clk); eng_cs_inactive = 1'b1;
    @(negedge clk); eng_cs_inactive = 1'b0;
    peek(4'd10, d); chk("R8 raw csi", d, 16'h4C);
    wr(4'd11, 16'h0002); peek(4'd10, d); chk("R9 clear rxu", d, 16'h48);
    wr(4'd11, 16'h0001); peek(4'd10, d); chk("R9 clear all", d, 16'h00);

    // R12 lock while enabled
    wr(4'd0, 16'h0001);
    wr(4'd4, 16'd5); wr(4'd5, 16'd6); wr(4'd6, 16'd7);
    peek(4'd4, d); chk("R12 rxthr locked", d, D - 1);
    peek(4'd5, d); chk("R12 txwm locked", d, D - 1);
    peek(4'd6, d); chk("R12 rxwm locked", d, D - 1);
    wr(4'd7, 16'h0002); peek(4'd7, d); chk("R12 dmactl open", d, 2);

    // R13 flush
    epush(16'h1111); epush(16'h2222);
    peek(4'd2, d); chk("R13 pre rxlvl", d, 2);
    wr(4'd0, 16'h0000);
    peek(4'd1, d); chk("R13 txlvl flushed", d, 0);
    peek(4'd2, d); chk("R13 rxlvl flushed", d, 0);
    peek(4'd10, d); chk("R13 raw after flush", d, 16'h01);
    wr(4'd4, 16'd5); peek(4'd4, d); chk("R12 rxthr open", d, 5);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule